// File: doc/BRIEF.md
# Three-Phase Gate Protection Controller

This block is the digital control core of a three-phase inverter pre-driver. Each phase has an active-high command for its upper switch and one for its lower switch. The block turns these into two registered gate enables per phase. Along the way it removes command pulses that are too short, blocks any phase that is asked to drive both switches together, and applies three separate protection paths. Those paths take digital flags from external comparators: over-current, control-supply undervoltage, and a per-phase upper-supply undervoltage.

A bus over-current that lasts past a blanking interval stops every gate and pulls the active-low fault output down. That output stays low until the over-current has gone away and a fault-clear hold has run out. Control-supply undervoltage also stops every gate, and holds the fault output low for as long as it lasts. An upper-supply undervoltage on one phase stops only that phase's upper gate and raises no fault. After any of these events a gate restarts only on a new activation of its command. All durations are counted in ticks. One tick is `TICK_DIV` clock cycles, and a single tick counter serves the whole block.

Top module: `gate_prot_ctrl`

## Requirements
- R1: With no protection active, gate_hi[p] follows hin[p] and gate_lo[p] follows lin[p], both active high, after the width filter, with bit p selecting phase p.
- R2: When hin[p] and lin[p] are both high after filtering, gate_hi[p] and gate_lo[p] are both low, and fault_n stays high.
- R3: A command level that lasts fewer than MINPW_TICKS ticks is ignored, for both high pulses and low gaps. A level that lasts MINPW_TICKS+1 ticks or longer is always taken.
- R4: When oc_flag stays high for more than BLANK_TICKS ticks, every gate enable goes low and fault_n goes low.
- R5: oc_flag pulses that last BLANK_TICKS-1 ticks or less never trip, even when they repeat.
- R6: After a trip, fault_n returns high only once oc_flag has been low for CLEAR_TICKS consecutive ticks. The count starts again if oc_flag rises. Recovery is automatic.
- R7: While uv_ctrl is high, every gate enable is low and fault_n is low.
- R8: While uv_hi[p] is high, gate_hi[p] is low. The other gates keep working and fault_n stays high.
- R9: After a fault hold, a control-supply undervoltage or an upper-supply undervoltage of its phase, a gate is driven only after its filtered command has been seen low and then high again.
- R10: While rst is high, all gate enables are low and fault_n is high on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hin | input | NPH | Upper-switch commands, one bit per phase |
| lin | input | NPH | Lower-switch commands, one bit per phase |
| oc_flag | input | 1 | Bus over-current comparator flag |
| uv_ctrl | input | 1 | Control-supply undervoltage flag |
| uv_hi | input | NPH | Upper-supply undervoltage flags, one bit per phase |
| gate_hi | output | NPH | Upper gate enables |
| gate_lo | output | NPH | Lower gate enables |
| fault_n | output | 1 | Fault indication, active low |

## Verification
The bench sends over-current pulses that repeat but never last past the blanking window. A design without blanking, or one that kept its count through the gaps, would trip on them. It sends narrow glitches both onto and out of an active command, which an unfiltered design would pass through to a gate.

The bench keeps over-current high long after the trip, so a design that runs the clear hold regardless of the flag would release too early. It checks the fault output both partway through the hold and after it, so a hold that is too short or never ends is caught.

It holds a command high through every fault and undervoltage event. A design that resumes at once instead of waiting for a fresh activation would drive the gate straight away. It also holds one phase in upper-supply undervoltage to check that the other phases still run and no fault is raised.

// File: rtl/gpc_pkg.sv
package gpc_pkg;

    // Fault-hold state of the protection sequencer
    typedef enum logic {
        HS_RUN  = 1'b0,
        HS_HOLD = 1'b1
    } hold_st_e;

    // Width of a counter that must reach the value n
    function automatic int cnt_w(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/gpc_tick_gen.sv
module gpc_tick_gen #(
    parameter int TICK_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = gpc_pkg::cnt_w(TICK_DIV);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tick;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.cnt == CW'(TICK_DIV - 1)) begin
            s_d.cnt  = '0;
            s_d.tick = 1'b1;
        end else begin
            s_d.cnt  = s_q.cnt + 1'b1;
            s_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign tick = s_q.tick;
endmodule

// File: rtl/gpc_width_filter.sv
// Adopts a new input level only after it has been held for MINPW_TICKS ticks.
module gpc_width_filter #(
    parameter int MINPW_TICKS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic raw,
    output logic filt
);
    localparam int CW = gpc_pkg::cnt_w(MINPW_TICKS);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          lvl;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (raw == s_q.lvl) begin
            s_d.cnt = '0;
        end else if (tick) begin
            if (s_q.cnt >= CW'(MINPW_TICKS - 1)) begin
                s_d.lvl = raw;
                s_d.cnt = '0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign filt = s_q.lvl;
endmodule

// File: rtl/gpc_oc_blanker.sv
// Reports a trip once over-current has been continuously present for BLANK_TICKS ticks.
module gpc_oc_blanker #(
    parameter int BLANK_TICKS = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic oc,
    output logic trip
);
    localparam int CW = gpc_pkg::cnt_w(BLANK_TICKS);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!oc)
            s_d.cnt = '0;
        else if (tick && (s_q.cnt != CW'(BLANK_TICKS)))
            s_d.cnt = s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign trip = oc && (s_q.cnt == CW'(BLANK_TICKS));
endmodule

// File: rtl/gpc_fault_timer.sv
// Holds the fault state until over-current has been absent for CLEAR_TICKS ticks.
module gpc_fault_timer #(
    parameter int CLEAR_TICKS = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic trip,
    input  logic oc,
    output logic hold
);
    import gpc_pkg::*;

    localparam int CW = cnt_w(CLEAR_TICKS);

    typedef struct packed {
        hold_st_e      st;
        logic [CW-1:0] cnt;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (trip) begin
            s_d.st  = HS_HOLD;
            s_d.cnt = '0;
        end else if (s_q.st == HS_HOLD) begin
            if (oc) begin
                s_d.cnt = '0;
            end else if (tick) begin
                if (s_q.cnt >= CW'(CLEAR_TICKS - 1)) begin
                    s_d.st  = HS_RUN;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.st  <= HS_RUN;
            s_q.cnt <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign hold = (s_q.st == HS_HOLD);
endmodule

// File: rtl/gate_prot_ctrl.sv
module gate_prot_ctrl #(
    parameter int NPH         = 3,
    parameter int TICK_DIV    = 4,
    parameter int MINPW_TICKS = 2,
    parameter int BLANK_TICKS = 3,
    parameter int CLEAR_TICKS = 20
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NPH-1:0] hin,
    input  logic [NPH-1:0] lin,
    input  logic           oc_flag,
    input  logic           uv_ctrl,
    input  logic [NPH-1:0] uv_hi,
    output logic [NPH-1:0] gate_hi,
    output logic [NPH-1:0] gate_lo,
    output logic           fault_n
);
    logic           tick;
    logic           trip;
    logic           hold;
    logic [NPH-1:0] hf;
    logic [NPH-1:0] lf;

    gpc_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk (clk), .rst (rst), .tick (tick)
    );

    for (genvar p = 0; p < NPH; p++) begin : g_filt
        gpc_width_filter #(.MINPW_TICKS(MINPW_TICKS)) u_hf (
            .clk (clk), .rst (rst), .tick (tick), .raw (hin[p]), .filt (hf[p])
        );
        gpc_width_filter #(.MINPW_TICKS(MINPW_TICKS)) u_lf (
            .clk (clk), .rst (rst), .tick (tick), .raw (lin[p]), .filt (lf[p])
        );
    end

    gpc_oc_blanker #(.BLANK_TICKS(BLANK_TICKS)) u_blank (
        .clk (clk), .rst (rst), .tick (tick), .oc (oc_flag), .trip (trip)
    );

    gpc_fault_timer #(.CLEAR_TICKS(CLEAR_TICKS)) u_timer (
        .clk (clk), .rst (rst), .tick (tick), .trip (trip), .oc (oc_flag), .hold (hold)
    );

    typedef struct packed {
        logic [NPH-1:0] arm_hi;
        logic [NPH-1:0] arm_lo;
        logic [NPH-1:0] g_hi;
        logic [NPH-1:0] g_lo;
        logic           flt_n;
    } st_t;

    st_t  s_d, s_q;
    logic blk;

    always_comb begin
        s_d   = s_q;
        blk   = hold | trip | uv_ctrl;
        s_d.flt_n = ~blk;
        for (int p = 0; p < NPH; p++) begin
            // re-arm on a low command; drop the arm whenever protection blocks
            if (blk || uv_hi[p])  s_d.arm_hi[p] = 1'b0;
            else if (!hf[p])      s_d.arm_hi[p] = 1'b1;
            if (blk)              s_d.arm_lo[p] = 1'b0;
            else if (!lf[p])      s_d.arm_lo[p] = 1'b1;

            s_d.g_hi[p] = ~blk & ~uv_hi[p] & s_q.arm_hi[p] & hf[p] & ~lf[p];
            s_d.g_lo[p] = ~blk & s_q.arm_lo[p] & lf[p] & ~hf[p];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q       <= '0;
            s_q.flt_n <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign gate_hi = s_q.g_hi;
    assign gate_lo = s_q.g_lo;
    assign fault_n = s_q.flt_n;
endmodule

// File: rtl/gate_prot_ctrl_chk.sv
module gate_prot_ctrl_chk #(
    parameter int NPH = 3
) (
    input logic           clk,
    input logic           rst,
    input logic           uv_ctrl,
    input logic [NPH-1:0] uv_hi,
    input logic [NPH-1:0] gate_hi,
    input logic [NPH-1:0] gate_lo,
    input logic           fault_n
);
    // R2: a phase never drives both switches
    a_r2_no_shoot: assert property (@(posedge clk) disable iff (rst)
        (gate_hi & gate_lo) == '0);

    // R7: control-supply undervoltage pulls the fault output low on the next edge
    a_r7_uvctrl_fault: assert property (@(posedge clk) disable iff (rst)
        uv_ctrl |=> !fault_n);

    // R4: no gate is driven while the fault output is low
    a_r4_fault_gates_off: assert property (@(posedge clk) disable iff (rst)
        !fault_n |-> (gate_hi == '0 && gate_lo == '0));

    // R8: an upper-supply undervoltage removes that phase's upper gate on the next edge
    a_r8_uvhi_off: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((gate_hi & $past(uv_hi)) == '0));

    // R10: reset leaves all gates off and no fault
    a_r10_reset_state: assert property (@(posedge clk)
        rst |=> (fault_n && gate_hi == '0 && gate_lo == '0));
endmodule

bind gate_prot_ctrl gate_prot_ctrl_chk #(.NPH(NPH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .uv_ctrl (uv_ctrl),
    .uv_hi   (uv_hi),
    .gate_hi (gate_hi),
    .gate_lo (gate_lo),
    .fault_n (fault_n)
);

// File: tb/gate_prot_ctrl_bench.sv
module gate_prot_ctrl_bench;
    localparam int NPH = 3;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NPH-1:0] hin = '0;
    logic [NPH-1:0] lin = '0;
    logic           oc_flag = 1'b0;
    logic           uv_ctrl = 1'b0;
    logic [NPH-1:0] uv_hi = '0;
    logic [NPH-1:0] gate_hi;
    logic [NPH-1:0] gate_lo;
    logic           fault_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    gate_prot_ctrl #(.NPH(NPH), .TICK_DIV(4), .MINPW_TICKS(2),
                     .BLANK_TICKS(3), .CLEAR_TICKS(20)) u_gate_prot_ctrl (
        .clk (clk), .rst (rst), .hin (hin), .lin (lin), .oc_flag (oc_flag),
        .uv_ctrl (uv_ctrl), .uv_hi (uv_hi), .gate_hi (gate_hi),
        .gate_lo (gate_lo), .fault_n (fault_n)
    );

    // fields: hin, lin, uv_hi, expected gate_hi, expected gate_lo
    localparam logic [14:0] VEC [10] = '{
        {3'b000, 3'b000, 3'b000, 3'b000, 3'b000},
        {3'b001, 3'b010, 3'b000, 3'b001, 3'b010},
        {3'b101, 3'b010, 3'b000, 3'b101, 3'b010},
        {3'b101, 3'b011, 3'b000, 3'b100, 3'b010},
        {3'b000, 3'b000, 3'b000, 3'b000, 3'b000},
        {3'b111, 3'b000, 3'b010, 3'b101, 3'b000},
        {3'b111, 3'b000, 3'b000, 3'b101, 3'b000},
        {3'b101, 3'b000, 3'b000, 3'b101, 3'b000},
        {3'b111, 3'b000, 3'b000, 3'b111, 3'b000},
        {3'b000, 3'b100, 3'b000, 3'b000, 3'b100}
    };

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    // Watch gate_hi[0] and fault_n every cycle for n cycles; returns count of bad cycles
    task automatic watch(input int n, input logic exp_g0, input logic exp_f, output int bad);
        bad = 0;
        for (int i = 0; i < n; i++) begin
            cyc(1);
            if (gate_hi[0] !== exp_g0 || fault_n !== exp_f) bad++;
        end
    endtask

    initial begin
        #(200000 * 8);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int bad;
        cyc(3);
        // R10 reset state
        chk("R10 gate_hi in reset", 32'(gate_hi), 0);
        chk("R10 gate_lo in reset", 32'(gate_lo), 0);
        chk("R10 fault_n in reset", 32'(fault_n), 1);
        rst = 1'b0;
        cyc(4);

        // R1 / R2 / R8 / R9 table walk
        for (int v = 0; v < 10; v++) begin
            hin   = VEC[v][14:12];
            lin   = VEC[v][11:9];
            uv_hi = VEC[v][8:6];
            cyc(24);
            chk($sformatf("R1 R2 R8 R9 gate_hi vec %0d", v), 32'(gate_hi), 32'(VEC[v][5:3]));
            chk($sformatf("R1 R2 R8 R9 gate_lo vec %0d", v), 32'(gate_lo), 32'(VEC[v][2:0]));
            chk($sformatf("R2 R8 fault_n vec %0d", v), 32'(fault_n), 1);
        end
        hin = '0; lin = '0;
        cyc(24);

        // R3 narrow high glitch is ignored
        hin[0] = 1'b1; cyc(3); hin[0] = 1'b0;
        watch(20, 1'b0, 1'b1, bad);
        chk("R3 high glitch ignored", 32'(bad), 0);
        hin[0] = 1'b1; cyc(24);
        chk("R3 long command taken", 32'(gate_hi[0]), 1);
        hin[0] = 1'b0; cyc(3); hin[0] = 1'b1;
        watch(20, 1'b1, 1'b1, bad);
        chk("R3 low glitch ignored", 32'(bad), 0);

        // R5 repeated short over-current pulses
        bad = 0;
        for (int k = 0; k < 5; k++) begin
            int b;
            oc_flag = 1'b1; watch(6, 1'b1, 1'b1, b); bad += b;
            oc_flag = 1'b0; watch(6, 1'b1, 1'b1, b); bad += b;
        end
        chk("R5 short oc pulses ignored", 32'(bad), 0);

        // R4 long over-current trips
        oc_flag = 1'b1; cyc(30);
        chk("R4 fault_n after long oc", 32'(fault_n), 0);
        chk("R4 gate_hi after long oc", 32'(gate_hi), 0);
        oc_flag = 1'b0; cyc(40);
        chk("R6 fault_n mid hold", 32'(fault_n), 0);
        cyc(60);
        chk("R6 fault_n after hold", 32'(fault_n), 1);
        cyc(20);
        chk("R9 gate_hi waits for fresh command after hold", 32'(gate_hi[0]), 0);
        hin[0] = 1'b0; cyc(20); hin[0] = 1'b1; cyc(20);
        chk("R9 gate_hi after fresh command", 32'(gate_hi[0]), 1);

        // R6 hold does not expire while oc stays high
        oc_flag = 1'b1; cyc(150);
        chk("R6 fault_n while oc persists", 32'(fault_n), 0);
        oc_flag = 1'b0; cyc(100);
        chk("R6 fault_n after persistent oc clears", 32'(fault_n), 1);
        hin[0] = 1'b0; cyc(20); hin[0] = 1'b1; cyc(20);

        // R7 control-supply undervoltage
        uv_ctrl = 1'b1; cyc(3);
        chk("R7 fault_n in uv", 32'(fault_n), 0);
        chk("R7 gate_hi in uv", 32'(gate_hi), 0);
        cyc(50);
        chk("R7 fault_n held in uv", 32'(fault_n), 0);
        uv_ctrl = 1'b0; cyc(3);
        chk("R7 fault_n after uv", 32'(fault_n), 1);
        cyc(20);
        chk("R9 gate_hi waits after uv", 32'(gate_hi[0]), 0);
        hin[0] = 1'b0; cyc(20); hin[0] = 1'b1; cyc(20);
        chk("R9 gate_hi after uv and fresh command", 32'(gate_hi[0]), 1);

        // R10 reset mid-run with active command
        rst = 1'b1; cyc(2);
        chk("R10 gate_hi in mid reset", 32'(gate_hi), 0);
        chk("R10 fault_n in mid reset", 32'(fault_n), 1);
        rst = 1'b0; hin = '0; cyc(10);

        finish_run();
    end
endmodule